// File: doc/BRIEF.md
# Receive Frame Ring Address Manager

This block generates local-memory byte addresses for received frames. Storage is a ring of 256-byte pages, bounded below by a first-page setting and above by an end-page setting; the end page itself is outside the ring. A frame begins at the page named by the current-page register. The first four bytes of that page are left free for a header, so the first payload byte goes to offset 4. When a page fills, the next byte goes to offset 0 of the following page. From the last page of the ring, the following page is the first page.

Before each move to a new page, the block compares that page with a guard page supplied by the host. The guard page marks the oldest frame the host has not yet read. If the two are equal, the frame is aborted: nothing more is written, and a sticky overflow flag is raised. This protects frames that are already stored.

A frame ends with a good or bad status. On a good end, the current page moves to the page after the last one written. On a bad end, or after an abort, the current page is left unchanged. That rolls back the frame's storage so the next frame overwrites it. The host may load the current page only while no frame is in progress.

Top module: `rx_ring_addr`

## Requirements
- R1: After reset, `cur_page` is 0, `mem_we` is 0 and `ovf_flag` is 0.
- R2: A `host_cur_load` pulse while no frame is active sets `cur_page` to `host_cur_val` on the next cycle. The same pulse while a frame is active leaves `cur_page` unchanged.
- R3: Within a frame, `mem_we` rises in the same cycle as each accepted `byte_stb`. `mem_addr` is {page[15:8], offset[7:0]}. The first byte goes to {cur_page, 4}, and each later byte goes to the next offset on the same page.
- R4: The byte after a write at offset 255 goes to offset 0 of the following page.
- R5: The page following `cfg_ring_end - 1` is `cfg_ring_first`.
- R6: If the following page equals `cfg_guard_page` when a byte needs it, that byte is not written and `ovf_flag` is 1 from the next cycle on. The remaining bytes of the frame are not written.
- R7: `ovf_flag` stays 1 after the aborted frame ends. It returns to 0 in the cycle after the next accepted `frm_start`.
- R8: A `frm_end` with `frm_good`=1 on a frame that was not aborted sets `cur_page` on the next cycle to the page following the last page written.
- R9: A `frm_end` with `frm_good`=0, or any end of an aborted frame, leaves `cur_page` unchanged.
- R10: The guard comparison uses the value `cfg_guard_page` has in the cycle the page change happens, even if that value was changed during the frame.
- R11: A `byte_stb` while no frame is active produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_first | input | 8 | First page of the ring |
| cfg_ring_end | input | 8 | Page just past the ring (exclusive) |
| cfg_guard_page | input | 8 | Oldest unread page; writing must not reach it |
| host_cur_load | input | 1 | Load strobe for the current page |
| host_cur_val | input | 8 | Value for the current-page load |
| frm_start | input | 1 | Start of an incoming frame |
| byte_stb | input | 1 | One payload byte is ready to be stored |
| frm_end | input | 1 | End of the frame |
| frm_good | input | 1 | Status that goes with `frm_end`: 1 = accepted, 0 = rejected |
| mem_addr | output | 16 | Byte address {page, offset} |
| mem_we | output | 1 | Write enable for `mem_addr` |
| ovf_flag | output | 1 | Ring overflow caused an abort |
| cur_page | output | 8 | Current page register |

## Verification
The bench runs five kinds of frame:
- A short frame that stays on one page. This checks the header offset and plain increments.
- A frame that crosses from the last ring page back to the first. This separates page linking from ring wraparound.
- A long rejected frame. This shows that rollback ignores pages already filled.
- A frame that runs into the guard page. This shows the abort and the sticky flag, unlike a plain rejection.
- A frame whose guard page is moved away in mid-frame. This proves the comparison uses the live value and not one captured at frame start.

Writes while idle and current-page loads during a frame are also tried. These show that both are ignored at the ports.

// File: rtl/rbr_pkg.sv
package rbr_pkg;

    parameter int unsigned RBR_PAGE_W = 8;
    parameter int unsigned RBR_OFF_W  = 8;
    parameter int unsigned RBR_ADDR_W = RBR_PAGE_W + RBR_OFF_W;

    typedef logic [RBR_PAGE_W-1:0] page_t;
    typedef logic [RBR_OFF_W-1:0]  off_t;

    typedef struct packed {
        page_t page;
        off_t  off;
    } ring_addr_t;

    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_RUN  = 2'd1,
        FILL_DROP = 2'd2
    } fill_state_e;

endpackage

// File: rtl/rbr_page_step.sv
module rbr_page_step
    import rbr_pkg::*;
(
    input  page_t page_in,
    input  page_t ring_first,
    input  page_t ring_end,
    input  page_t guard,
    output page_t page_next,
    output logic  guard_hit
);
    page_t incr;

    always_comb begin
        incr      = page_in + page_t'(1);
        page_next = (incr == ring_end) ? ring_first : incr;
        guard_hit = (page_next == guard);
    end
endmodule

// File: rtl/rbr_fill_ctrl.sv
module rbr_fill_ctrl
    import rbr_pkg::*;
#(
    parameter int unsigned HDR_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frm_start,
    input  logic       byte_stb,
    input  logic       frm_end,
    input  logic       frm_good,
    input  page_t      cur_page,
    input  page_t      step_next,
    input  logic       step_hit,
    output ring_addr_t wr_addr,
    output logic       wr_en,
    output page_t      wr_page,
    output logic       busy,
    output logic       start_acc,
    output logic       commit,
    output logic       abort_evt
);
    localparam off_t HDR_OFF  = off_t'(HDR_BYTES);
    localparam off_t OFF_LAST = '1;

    fill_state_e state_q;
    ring_addr_t  ptr_q;
    logic        link_pend_q;
    logic        link_now;
    logic        take_byte;

    always_comb begin
        busy      = (state_q != FILL_IDLE);
        start_acc = (state_q == FILL_IDLE) && frm_start;
        take_byte = (state_q == FILL_RUN) && byte_stb && !frm_end;
        link_now  = take_byte && link_pend_q;
        abort_evt = link_now && step_hit;
        wr_en     = take_byte && !abort_evt;
        commit    = (state_q == FILL_RUN) && frm_end && frm_good;
        wr_page   = ptr_q.page;
        if (link_now) begin
            wr_addr.page = step_next;
            wr_addr.off  = '0;
        end else begin
            wr_addr = ptr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FILL_IDLE;
            ptr_q       <= '0;
            link_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                FILL_IDLE: begin
                    if (frm_start) begin
                        state_q     <= FILL_RUN;
                        ptr_q.page  <= cur_page;
                        ptr_q.off   <= HDR_OFF;
                        link_pend_q <= 1'b0;
                    end
                end
                FILL_RUN: begin
                    if (frm_end) begin
                        state_q <= FILL_IDLE;
                    end else if (byte_stb) begin
                        if (link_pend_q) begin
                            if (step_hit) begin
                                state_q <= FILL_DROP;
                            end else begin
                                ptr_q.page  <= step_next;
                                ptr_q.off   <= off_t'(1);
                                link_pend_q <= 1'b0;
                            end
                        end else if (ptr_q.off == OFF_LAST) begin
                            link_pend_q <= 1'b1;
                        end else begin
                            ptr_q.off <= ptr_q.off + off_t'(1);
                        end
                    end
                end
                FILL_DROP: begin
                    if (frm_end) begin
                        state_q <= FILL_IDLE;
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr.off != OFF_LAST) ##1 wr_en
        |-> (wr_addr == $past(wr_addr) + ring_addr_t'(1))) else $error("offset step"); // R3

    AST_LINK_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr.off == OFF_LAST) ##1 wr_en
        |-> (wr_addr.off == '0)) else $error("link offset"); // R4

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(start_acc)) |-> !wr_en) else $error("idle write"); // R11
endmodule

// File: rtl/rbr_cur_reg.sv
module rbr_cur_reg
    import rbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_load,
    input  page_t host_val,
    input  logic  busy,
    input  logic  start_acc,
    input  logic  commit,
    input  page_t commit_val,
    input  logic  abort_evt,
    output page_t cur_page,
    output logic  ovf_flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_page <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (abort_evt) begin
                ovf_flag <= 1'b1;
            end else if (start_acc) begin
                ovf_flag <= 1'b0;
            end
            if (commit) begin
                cur_page <= commit_val;
            end else if (host_load && !busy) begin
                cur_page <= host_val;
            end
        end
    end

    AST_LOAD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (host_load && busy && !commit) |=> $stable(cur_page)) else $error("busy load"); // R2

    AST_ABORT_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        abort_evt |=> ovf_flag) else $error("abort flag"); // R6
endmodule

// File: rtl/rx_ring_addr.sv
module rx_ring_addr
    import rbr_pkg::*;
#(
    parameter int unsigned HDR_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RBR_PAGE_W-1:0] cfg_ring_first,
    input  logic [RBR_PAGE_W-1:0] cfg_ring_end,
    input  logic [RBR_PAGE_W-1:0] cfg_guard_page,
    input  logic                  host_cur_load,
    input  logic [RBR_PAGE_W-1:0] host_cur_val,
    input  logic                  frm_start,
    input  logic                  byte_stb,
    input  logic                  frm_end,
    input  logic                  frm_good,
    output logic [RBR_ADDR_W-1:0] mem_addr,
    output logic                  mem_we,
    output logic                  ovf_flag,
    output logic [RBR_PAGE_W-1:0] cur_page
);
    page_t      step_next;
    logic       step_hit;
    page_t      wr_page;
    ring_addr_t wr_addr;
    logic       busy;
    logic       start_acc;
    logic       commit;
    logic       abort_evt;

    rbr_page_step u_step (
        .page_in    (wr_page),
        .ring_first (cfg_ring_first),
        .ring_end   (cfg_ring_end),
        .guard      (cfg_guard_page),
        .page_next  (step_next),
        .guard_hit  (step_hit)
    );

    rbr_fill_ctrl #(.HDR_BYTES(HDR_BYTES)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .byte_stb  (byte_stb),
        .frm_end   (frm_end),
        .frm_good  (frm_good),
        .cur_page  (cur_page),
        .step_next (step_next),
        .step_hit  (step_hit),
        .wr_addr   (wr_addr),
        .wr_en     (mem_we),
        .wr_page   (wr_page),
        .busy      (busy),
        .start_acc (start_acc),
        .commit    (commit),
        .abort_evt (abort_evt)
    );

    rbr_cur_reg u_cur (
        .clk        (clk),
        .rst        (rst),
        .host_load  (host_cur_load),
        .host_val   (host_cur_val),
        .busy       (busy),
        .start_acc  (start_acc),
        .commit     (commit),
        .commit_val (step_next),
        .abort_evt  (abort_evt),
        .cur_page   (cur_page),
        .ovf_flag   (ovf_flag)
    );

    assign mem_addr = wr_addr;

    AST_FLAG_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> !mem_we) else $error("write after abort"); // R6

    AST_BAD_END_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (frm_end && !frm_good && busy) |=> $stable(cur_page)) else $error("bad end moved page"); // R9
endmodule

// File: tb/rx_ring_addr_bench.sv
module rx_ring_addr_bench;

    typedef struct {
        logic [15:0] addr;
        string       tag;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_ring_first = 8'h10;
    logic [7:0] cfg_ring_end   = 8'h14;
    logic [7:0] cfg_guard_page = 8'h40;
    logic       host_cur_load = 1'b0;
    logic [7:0] host_cur_val  = 8'h00;
    logic       frm_start = 1'b0;
    logic       byte_stb  = 1'b0;
    logic       frm_end   = 1'b0;
    logic       frm_good  = 1'b0;
    logic [15:0] mem_addr;
    logic       mem_we;
    logic       ovf_flag;
    logic [7:0] cur_page;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    exp_item_t exp_q[$];

    logic [7:0] m_cur = 8'h00;
    logic [7:0] m_wr;
    logic [7:0] m_off;
    bit         m_active = 1'b0;
    bit         m_link   = 1'b0;
    bit         m_abort  = 1'b0;

    rx_ring_addr u_rx_ring_addr (
        .clk            (clk),
        .rst            (rst),
        .cfg_ring_first (cfg_ring_first),
        .cfg_ring_end   (cfg_ring_end),
        .cfg_guard_page (cfg_guard_page),
        .host_cur_load  (host_cur_load),
        .host_cur_val   (host_cur_val),
        .frm_start      (frm_start),
        .byte_stb       (byte_stb),
        .frm_end        (frm_end),
        .frm_good       (frm_good),
        .mem_addr       (mem_addr),
        .mem_we         (mem_we),
        .ovf_flag       (ovf_flag),
        .cur_page       (cur_page)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] follow(input logic [7:0] p);
        logic [7:0] n;
        n = p + 8'd1;
        return (n == cfg_ring_end) ? cfg_ring_first : n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every write
    always begin
        @(negedge clk);
        #1;
        if (!rst && !done && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected write", mem_addr, 0);
            end else begin
                exp_item_t it;
                it = exp_q.pop_front();
                check(mem_addr == it.addr, it.tag, mem_addr, it.addr);
            end
        end
    end

    task automatic clear_strobes();
        host_cur_load = 1'b0;
        frm_start = 1'b0;
        byte_stb  = 1'b0;
        frm_end   = 1'b0;
        frm_good  = 1'b0;
    endtask

    task automatic idle_cyc();
        @(negedge clk);
        clear_strobes();
    endtask

    task automatic send_byte();
        exp_item_t it;
        @(negedge clk);
        clear_strobes();
        byte_stb = 1'b1;
        if (m_active && !m_abort) begin
            if (m_link) begin
                if (follow(m_wr) == cfg_guard_page) begin
                    m_abort = 1'b1;
                end else begin
                    m_wr   = follow(m_wr);
                    it.addr = {m_wr, 8'h00};
                    it.tag  = "R4 link address";
                    exp_q.push_back(it);
                    m_off  = 8'h01;
                    m_link = 1'b0;
                end
            end else begin
                it.addr = {m_wr, m_off};
                it.tag  = "R3 byte address";
                exp_q.push_back(it);
                if (m_off == 8'hFF) m_link = 1'b1;
                else m_off = m_off + 8'd1;
            end
        end
    endtask

    task automatic send_bytes(input int n);
        for (int i = 0; i < n; i++) send_byte();
        idle_cyc();
    endtask

    task automatic start_frame();
        @(negedge clk);
        clear_strobes();
        frm_start = 1'b1;
        m_active = 1'b1;
        m_wr     = m_cur;
        m_off    = 8'd4;
        m_link   = 1'b0;
        m_abort  = 1'b0;
        idle_cyc();
        #1;
        check(ovf_flag == 1'b0, "R7 flag cleared at start", ovf_flag, 0);
    endtask

    task automatic end_frame(input bit good);
        @(negedge clk);
        clear_strobes();
        frm_end  = 1'b1;
        frm_good = good;
        if (good && !m_abort) m_cur = follow(m_wr);
        m_active = 1'b0;
        idle_cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(cur_page == 8'h00, "R1 cur_page after reset", cur_page, 0);
        check(mem_we == 1'b0, "R1 mem_we after reset", mem_we, 0);
        check(ovf_flag == 1'b0, "R1 ovf_flag after reset", ovf_flag, 0);

        // R11: byte strobe while idle
        send_byte();
        #1;
        check(mem_we == 1'b0, "R11 idle byte no write", mem_we, 0);
        idle_cyc();

        // R2: load while idle
        @(negedge clk);
        host_cur_load = 1'b1;
        host_cur_val  = 8'h12;
        m_cur = 8'h12;
        idle_cyc();
        #1;
        check(cur_page == 8'h12, "R2 idle load", cur_page, 8'h12);

        // short frame on one page
        start_frame();
        send_bytes(10);
        end_frame(1'b1);
        #1;
        check(cur_page == 8'h13, "R8 good end advance", cur_page, 8'h13);

        // frame crossing the ring end
        start_frame();
        send_bytes(257);
        end_frame(1'b1);
        #1;
        check(cur_page == 8'h11, "R5 wrap to ring first", cur_page, 8'h11);

        // long rejected frame with a load attempt while busy
        start_frame();
        send_bytes(100);
        @(negedge clk);
        host_cur_load = 1'b1;
        host_cur_val  = 8'h55;
        idle_cyc();
        #1;
        check(cur_page == 8'h11, "R2 busy load ignored", cur_page, 8'h11);
        send_bytes(200);
        end_frame(1'b0);
        #1;
        check(cur_page == 8'h11, "R9 bad end rollback", cur_page, 8'h11);

        // overflow against the guard page
        cfg_guard_page = 8'h12;
        start_frame();
        send_bytes(252);
        send_byte();
        #1;
        check(mem_we == 1'b0, "R6 blocked byte not written", mem_we, 0);
        idle_cyc();
        #1;
        check(ovf_flag == 1'b1, "R6 overflow flag raised", ovf_flag, 1);
        send_bytes(3);
        end_frame(1'b1);
        #1;
        check(cur_page == 8'h11, "R9 aborted frame rollback", cur_page, 8'h11);
        check(ovf_flag == 1'b1, "R7 flag held after end", ovf_flag, 1);

        // guard moved away mid-frame
        start_frame();
        send_bytes(252);
        @(negedge clk);
        cfg_guard_page = 8'h40;
        send_byte();
        #1;
        check(mem_we == 1'b1 && mem_addr == 16'h1200, "R10 live guard value",
              {mem_we, mem_addr}, {1'b1, 16'h1200});
        idle_cyc();
        end_frame(1'b1);
        #1;
        check(cur_page == 8'h13, "R8 advance after link", cur_page, 8'h13);
        check(ovf_flag == 1'b0, "R7 no flag on clean frame", ovf_flag, 0);

        repeat (3) idle_cyc();
        check(exp_q.size() == 0, "R3 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule